// File: doc/BRIEF.md
# Bit Error Rate Receiver Monitor

This block sits on the receive side of a bit-error-rate tester. It takes one recovered bit per clock when `rx_valid` is high and builds its own copy of the transmitted pattern. It aligns that copy to the incoming stream and then compares the two bit by bit. The reference is either a programmable repeating 16-bit word or a 7-stage pseudorandom sequence with feedback polynomial x^7 + x^6 + 1.

Once aligned, the monitor keeps four saturating statistics: bit errors, compared bits, errored seconds and elapsed seconds. Software reads these counters and forms the error ratio and the errored-second ratio. A one-cycle `sec_tick` pulse marks each second boundary. If too many errors arrive within a short window, the monitor declares the link out of sync and starts a fresh alignment.

Top module: `bert_rx_monitor`

## Requirements
- R1: With `mode`=1 (pseudorandom), the first 7 valid bits after acquisition starts are loaded as the reference state. From then on, each expected bit is the XOR of the bits 6 and 7 positions earlier in the sequence. `in_sync` goes high right after the clock edge that takes the 16th consecutive matching bit, which is the 23rd valid bit of a clean stream.
- R2: In pseudorandom mode, a mismatch while hunting for alignment discards the loaded state and restarts loading. A clean stream then locks 23 valid bits after the bad bit.
- R3: With `mode`=0 (fixed word), `fixed_word[15]` is the first bit of each word period. On a mismatch while hunting, the reference position holds; on a match, it advances by one. `in_sync` rises after 16 consecutive matches.
- R4: While in sync, every valid bit adds one to `bit_count`, and every valid bit that differs from the reference adds one to `err_count`. Bits seen during acquisition are not counted.
- R5: Sync windows are consecutive blocks of 64 valid bits, starting with the first bit after lock. The 9th error within one window drops `in_sync` after that bit's edge, and that bit is still counted. Eight errors in each window keep sync.
- R6: After loss of sync, the monitor reacquires from scratch. A clean pseudorandom stream locks again after 23 valid bits.
- R7: A `sec_tick` while in sync adds one to `sec_count`. It also adds one to `errsec_count` if any in-sync error occurred since the previous tick, including an error in the same cycle as the tick. Each tick starts a new errored-second interval.
- R8: While out of sync, ticks, bits and errors change no counter.
- R9: Every counter stops at its all-ones value instead of wrapping.
- R10: `clr` zeroes all four counters and the errored-second flag in the next cycle. It leaves `in_sync` untouched.
- R11: A change of `mode` drops `in_sync` at the next edge and restarts acquisition in the new mode.
- R12: After reset, `in_sync` is 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous counter clear |
| rx_bit | input | 1 | Received data bit |
| rx_valid | input | 1 | `rx_bit` holds a bit to compare this cycle |
| mode | input | 1 | Reference type: 0 fixed word, 1 pseudorandom |
| fixed_word | input | WORD_W (16) | Repeating word, sent MSB first |
| sec_tick | input | 1 | One-cycle pulse at each second boundary |
| in_sync | output | 1 | Reference aligned; statistics running |
| err_count | output | CNT_W (32) | Bit errors counted while in sync |
| bit_count | output | CNT_W (32) | Bits compared while in sync |
| errsec_count | output | CNT_W (32) | Seconds that contained an error |
| sec_count | output | CNT_W (32) | Seconds elapsed while in sync |

## Verification
The assertions check several properties on every cycle:
- The error and bit counters move by at most one per cycle, and errors never exceed bits.
- Errored seconds never exceed seconds.
- Nothing counts while the monitor is out of sync.
- `clr` empties every counter.
- Sync only rises on a valid bit.
- Sync only falls on a valid bit or a mode change.

The exact lock points need the bench's scenarios: 23 bits for the sequence, and offset-dependent counts for the fixed word. So do the 9th-error window boundary, recovery after a slip, the errored-second accounting around ticks, and saturation.

// File: rtl/bertmon_pkg.sv
package bertmon_pkg;

    typedef enum logic [1:0] {
        ST_SEED = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } mon_state_t;

    localparam int PRBS_LEN    = 7;
    localparam int PRBS_TAP_HI = 6;
    localparam int PRBS_TAP_LO = 5;

    typedef logic [PRBS_LEN-1:0] prbs_state_t;

    typedef struct packed {
        logic counted;
        logic bit_err;
    } cmp_evt_t;

    localparam int STAT_NUM = 4;
    localparam int STAT_BITS   = 0;
    localparam int STAT_ERRS   = 1;
    localparam int STAT_SECS   = 2;
    localparam int STAT_ERRSEC = 3;

    function automatic logic prbs_predict(prbs_state_t s);
        return s[PRBS_TAP_HI] ^ s[PRBS_TAP_LO];
    endfunction

    function automatic mon_state_t acq_entry(logic prbs_mode);
        return prbs_mode ? ST_SEED : ST_HUNT;
    endfunction

endpackage

// File: rtl/bertmon_ref.sv
module bertmon_ref
    import bertmon_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic [WORD_W-1:0] fixed_word,
    input  logic              valid,
    input  logic              rx_bit,
    input  logic              mismatch,
    input  mon_state_t        state,
    output logic              ref_bit
);
    localparam int PTR_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WORD_W - 1);

    prbs_state_t      prbs_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] idx;
    logic             prbs_ref;
    logic             word_ref;

    assign prbs_ref = prbs_predict(prbs_q);
    assign idx      = PTR_LAST - ptr_q;
    assign word_ref = fixed_word[idx];
    assign ref_bit  = mode ? prbs_ref : word_ref;

    // Sequence register: loads received bits while seeding, free-runs otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            prbs_q <= '0;
        end else if (valid) begin
            if (state == ST_SEED)
                prbs_q <= {prbs_q[PRBS_LEN-2:0], rx_bit};
            else
                prbs_q <= {prbs_q[PRBS_LEN-2:0], prbs_ref};
        end
    end

    // Word position: slips (holds) on a hunting mismatch, else advances.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (valid && (state == ST_LOCK || !mismatch)) begin
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/bertmon_align.sv
module bertmon_align
    import bertmon_pkg::*;
#(
    parameter int LOCK_RUN = 16,
    parameter int WIN_LEN  = 64,
    parameter int LOSS_LIM = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode,
    input  logic       valid,
    input  logic       mismatch,
    output mon_state_t state,
    output cmp_evt_t   evt
);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);
    localparam int WIN_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int LIM_W  = $clog2(LOSS_LIM + 1);
    localparam int SEED_W = $clog2(PRBS_LEN + 1);
    localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(LOCK_RUN - 1);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_LEN - 1);
    localparam logic [LIM_W-1:0]  LIM_VAL   = LIM_W'(LOSS_LIM);
    localparam logic [SEED_W-1:0] SEED_LAST = SEED_W'(PRBS_LEN - 1);

    mon_state_t        state_q;
    logic              mode_q;
    logic [SEED_W-1:0] seed_cnt;
    logic [RUN_W-1:0]  run_cnt;
    logic [WIN_W-1:0]  win_pos;
    logic [LIM_W-1:0]  win_err;
    logic              mode_chg;

    assign mode_chg = (mode != mode_q);
    assign state    = state_q;

    always_comb begin
        evt.counted = valid && (state_q == ST_LOCK) && !mode_chg;
        evt.bit_err = evt.counted && mismatch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= acq_entry(mode);
            mode_q   <= mode;
            seed_cnt <= '0;
            run_cnt  <= '0;
            win_pos  <= '0;
            win_err  <= '0;
        end else if (mode_chg) begin
            state_q  <= acq_entry(mode);
            mode_q   <= mode;
            seed_cnt <= '0;
            run_cnt  <= '0;
        end else if (valid) begin
            unique case (state_q)
                ST_SEED: begin
                    if (seed_cnt == SEED_LAST) begin
                        state_q <= ST_HUNT;
                        run_cnt <= '0;
                    end else begin
                        seed_cnt <= seed_cnt + 1'b1;
                    end
                end
                ST_HUNT: begin
                    if (mismatch) begin
                        run_cnt <= '0;
                        if (mode) begin
                            state_q  <= ST_SEED;
                            seed_cnt <= '0;
                        end
                    end else if (run_cnt == RUN_LAST) begin
                        state_q <= ST_LOCK;
                        win_pos <= '0;
                        win_err <= '0;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (mismatch && win_err == LIM_VAL) begin
                        state_q  <= acq_entry(mode);
                        seed_cnt <= '0;
                        run_cnt  <= '0;
                    end else if (win_pos == WIN_LAST) begin
                        win_pos <= '0;
                        win_err <= '0;
                    end else begin
                        win_pos <= win_pos + 1'b1;
                        win_err <= win_err + LIM_W'(mismatch);
                    end
                end
                default: state_q <= acq_entry(mode);
            endcase
        end
    end

endmodule

// File: rtl/bertmon_satcnt.sv
module bertmon_satcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc && count != '1)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/bertmon_stats.sv
module bertmon_stats
    import bertmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  cmp_evt_t         evt,
    input  logic             locked,
    input  logic             tick,
    output logic [CNT_W-1:0] bits,
    output logic [CNT_W-1:0] errs,
    output logic [CNT_W-1:0] secs,
    output logic [CNT_W-1:0] errsecs
);
    logic                errsec_flag;
    logic [STAT_NUM-1:0] inc;
    logic [CNT_W-1:0]    cnt [STAT_NUM];

    always_comb begin
        inc              = '0;
        inc[STAT_BITS]   = evt.counted;
        inc[STAT_ERRS]   = evt.bit_err;
        inc[STAT_SECS]   = tick && locked;
        inc[STAT_ERRSEC] = tick && locked && (errsec_flag || evt.bit_err);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || tick)
            errsec_flag <= 1'b0;
        else if (evt.bit_err)
            errsec_flag <= 1'b1;
    end

    for (genvar g = 0; g < STAT_NUM; g++) begin : g_cnt
        bertmon_satcnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr),
            .inc   (inc[g]),
            .count (cnt[g])
        );
    end

    assign bits    = cnt[STAT_BITS];
    assign errs    = cnt[STAT_ERRS];
    assign secs    = cnt[STAT_SECS];
    assign errsecs = cnt[STAT_ERRSEC];

endmodule

// File: rtl/bert_rx_monitor.sv
module bert_rx_monitor
    import bertmon_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int LOCK_RUN = 16,
    parameter int WIN_LEN  = 64,
    parameter int LOSS_LIM = 8,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rx_bit,
    input  logic              rx_valid,
    input  logic              mode,
    input  logic [WORD_W-1:0] fixed_word,
    input  logic              sec_tick,
    output logic              in_sync,
    output logic [CNT_W-1:0]  err_count,
    output logic [CNT_W-1:0]  bit_count,
    output logic [CNT_W-1:0]  errsec_count,
    output logic [CNT_W-1:0]  sec_count
);
    mon_state_t state;
    cmp_evt_t   evt;
    logic       ref_bit;
    logic       mismatch;

    assign mismatch = rx_bit ^ ref_bit;
    assign in_sync  = (state == ST_LOCK);

    bertmon_ref #(.WORD_W(WORD_W)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .fixed_word (fixed_word),
        .valid      (rx_valid),
        .rx_bit     (rx_bit),
        .mismatch   (mismatch),
        .state      (state),
        .ref_bit    (ref_bit)
    );

    bertmon_align #(
        .LOCK_RUN (LOCK_RUN),
        .WIN_LEN  (WIN_LEN),
        .LOSS_LIM (LOSS_LIM)
    ) u_align (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .valid    (rx_valid),
        .mismatch (mismatch),
        .state    (state),
        .evt      (evt)
    );

    bertmon_stats #(.CNT_W(CNT_W)) u_stats (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .evt     (evt),
        .locked  (in_sync),
        .tick    (sec_tick),
        .bits    (bit_count),
        .errs    (err_count),
        .secs    (sec_count),
        .errsecs (errsec_count)
    );

endmodule

// File: rtl/bertmon_checker.sv
module bertmon_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             rx_valid,
    input logic             mode,
    input logic             in_sync,
    input logic [CNT_W-1:0] err_count,
    input logic [CNT_W-1:0] bit_count,
    input logic [CNT_W-1:0] errsec_count,
    input logic [CNT_W-1:0] sec_count
);
    a_r4_err_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

    a_r4_bit_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (bit_count == $past(bit_count) || bit_count == $past(bit_count) + 1'b1));

    a_r4_err_le_bits: assert property (@(posedge clk) disable iff (rst)
        err_count <= bit_count);

    a_r7_errsec_le_sec: assert property (@(posedge clk) disable iff (rst)
        errsec_count <= sec_count);

    a_r8_idle_bits: assert property (@(posedge clk) disable iff (rst)
        (!in_sync && !clr) |=> $stable(bit_count));

    a_r8_idle_errs: assert property (@(posedge clk) disable iff (rst)
        (!in_sync && !clr) |=> $stable(err_count));

    a_r8_idle_secs: assert property (@(posedge clk) disable iff (rst)
        (!in_sync && !clr) |=> ($stable(sec_count) && $stable(errsec_count)));

    a_r10_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (err_count == '0 && bit_count == '0 && sec_count == '0 && errsec_count == '0));

    a_r1_lock_on_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(rx_valid));

    a_r5_drop_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(in_sync) |-> ($past(rx_valid) || $past(mode) != $past(mode, 2)));

    a_r11_mode_drop: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |=> !in_sync);

endmodule

bind bert_rx_monitor bertmon_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .rx_valid     (rx_valid),
    .mode         (mode),
    .in_sync      (in_sync),
    .err_count    (err_count),
    .bit_count    (bit_count),
    .errsec_count (errsec_count),
    .sec_count    (sec_count)
);

// File: tb/sim_bert_rx_monitor.sv
module sim_bert_rx_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_valid = 1'b0;
    logic        mode = 1'b1;
    logic [15:0] fixed_word = 16'h0000;
    logic        sec_tick = 1'b0;
    logic        in_sync;
    logic [31:0] err_count, bit_count, errsec_count, sec_count;
    logic        s_sync;
    logic [3:0]  s_err, s_bits, s_errsec, s_sec;

    int errors = 0;
    int checks = 0;
    logic [6:0] tx = 7'h5A;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bert_rx_monitor u0 (
        .clk(clk), .rst(rst), .clr(clr), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .mode(mode), .fixed_word(fixed_word), .sec_tick(sec_tick),
        .in_sync(in_sync), .err_count(err_count), .bit_count(bit_count),
        .errsec_count(errsec_count), .sec_count(sec_count)
    );

    bert_rx_monitor #(.CNT_W(4)) u1 (
        .clk(clk), .rst(rst), .clr(clr), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .mode(mode), .fixed_word(fixed_word), .sec_tick(sec_tick),
        .in_sync(s_sync), .err_count(s_err), .bit_count(s_bits),
        .errsec_count(s_errsec), .sec_count(s_sec)
    );

    // word, stream offset, expected bit count at lock
    localparam logic [35:0] FIX_TAB [5] = '{
        {16'h8000, 4'd0, 16'd16},
        {16'h8000, 4'd1, 16'd31},
        {16'h00FF, 4'd8, 16'd24},
        {16'hFFFF, 4'd5, 16'd16},
        {16'h0001, 4'd0, 16'd16}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input logic b, input logic tk);
        rx_bit   = b;
        rx_valid = 1'b1;
        sec_tick = tk;
        step();
        rx_valid = 1'b0;
        sec_tick = 1'b0;
    endtask

    task automatic prbs_push(input logic flip, input logic tk);
        logic nb;
        nb = tx[6] ^ tx[5];
        tx = {tx[5:0], nb};
        push(nb ^ flip, tk);
    endtask

    task automatic prbs_run(input int n);
        for (int i = 0; i < n; i++) prbs_push(1'b0, 1'b0);
    endtask

    task automatic tick_only();
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step();
        // Fixed-word table
        for (int t = 0; t < 5; t++) begin
            logic [15:0] w;
            int off, lockn, pos;
            w = FIX_TAB[t][35:20];
            off = int'(FIX_TAB[t][19:16]);
            lockn = int'(FIX_TAB[t][15:0]);
            mode = 1'b0;
            fixed_word = w;
            do_reset();
            pos = off;
            for (int i = 0; i < lockn - 1; i++) begin
                push(w[15 - (pos % 16)], 1'b0);
                pos++;
            end
            chk("R3 no lock before run", 32'(in_sync), 0);
            push(w[15 - (pos % 16)], 1'b0);
            pos++;
            chk("R3 lock after run", 32'(in_sync), 1);
            for (int i = 0; i < 32; i++) begin
                push(w[15 - (pos % 16)], 1'b0);
                pos++;
            end
            chk("R4 word errs", err_count, 0);
            chk("R4 word bits", bit_count, 32);
        end

        // Pseudorandom lock, loss window, reacquire
        mode = 1'b1;
        do_reset();
        step();
        chk("R12 reset sync", 32'(in_sync), 0);
        chk("R12 reset errs", err_count, 0);
        chk("R12 reset bits", bit_count, 0);
        chk("R12 reset secs", sec_count, 0);
        chk("R12 reset errsecs", errsec_count, 0);
        prbs_run(22);
        chk("R1 no lock at 22", 32'(in_sync), 0);
        chk("R4 acq not counted", bit_count, 0);
        prbs_run(1);
        chk("R1 lock at 23", 32'(in_sync), 1);
        for (int i = 0; i < 8; i++) prbs_push(1'b1, 1'b0);
        prbs_run(56);
        for (int i = 0; i < 8; i++) prbs_push(1'b1, 1'b0);
        chk("R5 eight per window keeps sync", 32'(in_sync), 1);
        chk("R4 errs", err_count, 16);
        chk("R4 bits", bit_count, 72);
        chk("R9 errs saturate", 32'(s_err), 15);
        chk("R9 bits saturate", 32'(s_bits), 15);
        prbs_push(1'b1, 1'b0);
        chk("R5 ninth error drops sync", 32'(in_sync), 0);
        chk("R5 ninth error counted", err_count, 17);
        prbs_run(22);
        chk("R6 no relock at 22", 32'(in_sync), 0);
        chk("R8 bits frozen out of sync", bit_count, 73);
        prbs_run(1);
        chk("R6 relock at 23", 32'(in_sync), 1);

        // Hunt error restarts seeding
        do_reset();
        prbs_run(10);
        prbs_push(1'b1, 1'b0);
        prbs_run(22);
        chk("R2 no lock 22 after hunt error", 32'(in_sync), 0);
        prbs_run(1);
        chk("R2 lock 23 after hunt error", 32'(in_sync), 1);

        // Seconds
        tick_only();
        chk("R7 clean second", sec_count, 1);
        chk("R7 clean second errsec", errsec_count, 0);
        prbs_push(1'b1, 1'b0);
        prbs_run(3);
        tick_only();
        chk("R7 errored second secs", sec_count, 2);
        chk("R7 errored second errsec", errsec_count, 1);
        tick_only();
        chk("R7 flag cleared by tick", errsec_count, 1);
        prbs_push(1'b1, 1'b1);
        chk("R7 same-cycle error errsec", errsec_count, 2);
        chk("R7 same-cycle secs", sec_count, 4);
        chk("R4 errs after seconds", err_count, 2);

        // Clear
        clr = 1'b1;
        step();
        clr = 1'b0;
        chk("R10 clr errs", err_count, 0);
        chk("R10 clr bits", bit_count, 0);
        chk("R10 clr secs", sec_count, 0);
        chk("R10 clr errsecs", errsec_count, 0);
        chk("R10 clr keeps sync", 32'(in_sync), 1);
        prbs_run(2);
        chk("R10 counting resumes", bit_count, 2);

        // Mode change and out-of-sync activity
        mode = 1'b0;
        fixed_word = 16'h1234;
        step();
        chk("R11 mode change drops sync", 32'(in_sync), 0);
        tick_only();
        chk("R8 tick out of sync", sec_count, 0);
        for (int i = 0; i < 4; i++) push(1'b1, 1'b0);
        chk("R8 bits out of sync", bit_count, 2);
        chk("R8 errs out of sync", err_count, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule